// File: doc/BRIEF.md
# Block Address Translation Array

This block maps a 32-bit effective address onto a 32-bit physical address using a small set of software-programmed block windows. Each window holds a base effective address, a size mask, a physical base, a pair of privilege-qualified valid bits and a two-bit protection code. Every lookup compares the effective address against all windows in the same cycle. Each window covers a power-of-two region from 128 KB to 256 MB.

The block also receives the hit flag and physical address produced by a page-based TLB lookup for the same access. It merges the two results. A block window always takes precedence over the page TLB. One instance serves instruction fetches and a second serves data accesses. The result is registered and appears exactly one cycle after the request.

Software programs a whole window in one write cycle by giving an index and the field values.

Top module: `bxlat_unit`

## Requirements
- R1: After synchronous reset every window is invalid, and `rsp_valid`, `rsp_hit`, `rsp_fault`, `rsp_from_block` and `rsp_pa` are all zero.
- R2: A request presented with `req_valid` high at a rising edge produces `rsp_valid` high, with its result, after that edge. A cycle with `req_valid` low produces `rsp_valid` low.
- R3: Mask bit i (0..10) of `cfg_mask` corresponds to effective address bit 17+i. A set mask bit removes that bit from the compare and copies it from the effective address into the physical address. Effective bits [31:17] whose mask bit is clear must equal `cfg_ebase`, and those bits of the result come from `cfg_pbase`. Bits [16:0] always pass through unchanged.
- R4: A window whose mask is not a run of contiguous low-order ones never matches.
- R5: When several windows match, the lowest-numbered one supplies the result.
- R6: A window is usable only if `cfg_vu` is set for a user access (`req_user`=1), or `cfg_vs` is set for a supervisor access (`req_user`=0).
- R7: Protection code 00 faults every access, 01 faults writes only, and 10 or 11 allows reads and writes. On a fault the result has hit 0, fault 1, from_block 1 and a physical address of 0.
- R8: When the selected window matches, its result is used with `rsp_from_block`=1, even when `tlb_hit` is high.
- R9: When no window matches and `tlb_hit` is high, the result is hit 1, from_block 0 and `tlb_pa`. When neither source hits, hit, fault and pa are all 0.
- R10: In a cycle without a request, the following response has hit 0 and fault 0.
- R11: A window write takes effect from the next cycle. A lookup in the same cycle as the write sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write one window |
| cfg_idx | input | 2 | Window index to write |
| cfg_ebase | input | 15 | Effective base, address bits [31:17] |
| cfg_mask | input | 11 | Size mask over address bits [27:17] |
| cfg_pbase | input | 15 | Physical base, address bits [31:17] |
| cfg_vs | input | 1 | Valid for supervisor accesses |
| cfg_vu | input | 1 | Valid for user accesses |
| cfg_prot | input | 2 | Protection code |
| req_valid | input | 1 | Lookup request |
| req_ea | input | 32 | Effective address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is at user privilege |
| tlb_hit | input | 1 | Page TLB hit for this access |
| tlb_pa | input | 32 | Page TLB physical address |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_fault | output | 1 | Block protection fault |
| rsp_from_block | output | 1 | Result came from a block window |
| rsp_pa | output | 32 | Physical address |

## Verification
The hardest case to reach from the ports is several windows that match the same address at once while carrying different protection and privilege settings. That case shows whether the lowest index wins before protection is applied, or whether a faulting low window wrongly hands the access to a higher window or to the TLB. Directed tests program overlapping windows of different sizes with conflicting settings. The random phase draws effective addresses by flipping only masked bits of a chosen window's base. Most lookups therefore land inside one or more programmed windows rather than missing everywhere. Odd masks and same-cycle write and lookup are mixed in.

// File: rtl/bxlat_pkg.sv
package bxlat_pkg;
    localparam int EA_W    = 32;
    localparam int BLK_LSB = 17;
    localparam int TAG_W   = EA_W - BLK_LSB;
    localparam int MSK_W   = 11;
    localparam int N_DEF   = 4;

    typedef enum logic [1:0] {
        PROT_NONE = 2'b00,
        PROT_RO   = 2'b01,
        PROT_RW   = 2'b10,
        PROT_RWX  = 2'b11
    } prot_e;

    typedef struct packed {
        logic [TAG_W-1:0] ebase;
        logic [MSK_W-1:0] mask;
        logic [TAG_W-1:0] pbase;
        logic             vs;
        logic             vu;
        prot_e            prot;
    } win_t;

    typedef struct packed {
        logic            hit;
        logic            fault;
        logic            from_blk;
        logic [EA_W-1:0] pa;
    } xres_t;

    function automatic logic mask_is_run(input logic [MSK_W-1:0] m);
        logic [MSK_W-1:0] inc;
        inc = m + 1'b1;
        return (m & inc) == '0;
    endfunction

    function automatic logic [TAG_W-1:0] widen_mask(input logic [MSK_W-1:0] m);
        return {{(TAG_W-MSK_W){1'b0}}, m};
    endfunction

    function automatic logic access_ok(input prot_e p, input logic wr);
        case (p)
            PROT_NONE: return 1'b0;
            PROT_RO:   return !wr;
            default:   return 1'b1;
        endcase
    endfunction
endpackage

// File: rtl/bxlat_regs.sv
module bxlat_regs
    import bxlat_pkg::*;
#(
    parameter int N_ENT = N_DEF,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [IDX_W-1:0]       idx,
    input  win_t                   wdata,
    output win_t [N_ENT-1:0]       ents
);
    win_t [N_ENT-1:0] ents_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ents_q <= '0;
        end else if (we) begin
            ents_q[idx] <= wdata;
        end
    end

    assign ents = ents_q;

    for (genvar g = 0; g < N_ENT; g++) begin : g_chk
        assert_write_lands_R11: assert property (@(posedge clk) disable iff (rst)
            (we && idx == IDX_W'(g)) |=> ents[g] == $past(wdata));
        assert_other_kept_R11: assert property (@(posedge clk) disable iff (rst)
            !(we && idx == IDX_W'(g)) |=> $stable(ents[g]));
    end
endmodule

// File: rtl/bxlat_cmp.sv
module bxlat_cmp
    import bxlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  win_t             ent,
    input  logic [EA_W-1:0]  ea,
    input  logic             user,
    input  logic             wr,
    output logic             match,
    output logic             viol,
    output logic [EA_W-1:0]  pa
);
    logic [TAG_W-1:0] mext;
    logic [TAG_W-1:0] ea_tag;
    logic             tag_eq;
    logic             priv_ok;
    logic             shape_ok;

    always_comb begin
        mext     = widen_mask(ent.mask);
        ea_tag   = ea[EA_W-1:BLK_LSB];
        tag_eq   = ((ea_tag ^ ent.ebase) & ~mext) == '0;
        priv_ok  = user ? ent.vu : ent.vs;
        shape_ok = mask_is_run(ent.mask);
        match    = tag_eq && priv_ok && shape_ok;
        viol     = !access_ok(ent.prot, wr);
        pa       = {(ent.pbase & ~mext) | (ea_tag & mext), ea[BLK_LSB-1:0]};
    end

    assert_bad_mask_never_hits_R4: assert property (@(posedge clk) disable iff (rst)
        !mask_is_run(ent.mask) |-> !match);
    assert_low_bits_pass_R3: assert property (@(posedge clk) disable iff (rst)
        pa[BLK_LSB-1:0] == ea[BLK_LSB-1:0]);
endmodule

// File: rtl/bxlat_unit.sv
module bxlat_unit
    import bxlat_pkg::*;
#(
    parameter int N_ENT = N_DEF,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [TAG_W-1:0]  cfg_ebase,
    input  logic [MSK_W-1:0]  cfg_mask,
    input  logic [TAG_W-1:0]  cfg_pbase,
    input  logic              cfg_vs,
    input  logic              cfg_vu,
    input  logic [1:0]        cfg_prot,
    input  logic              req_valid,
    input  logic [EA_W-1:0]   req_ea,
    input  logic              req_write,
    input  logic              req_user,
    input  logic              tlb_hit,
    input  logic [EA_W-1:0]   tlb_pa,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_fault,
    output logic              rsp_from_block,
    output logic [EA_W-1:0]   rsp_pa
);
    win_t                  wdata;
    win_t [N_ENT-1:0]      ents;
    logic [N_ENT-1:0]      match_v;
    logic [N_ENT-1:0]      viol_v;
    logic [EA_W-1:0]       pa_v [N_ENT];
    logic                  any_blk;
    logic [IDX_W-1:0]      sel;
    xres_t                 nxt;
    xres_t                 res_q;
    logic                  vld_q;

    always_comb begin
        wdata.ebase = cfg_ebase;
        wdata.mask  = cfg_mask;
        wdata.pbase = cfg_pbase;
        wdata.vs    = cfg_vs;
        wdata.vu    = cfg_vu;
        wdata.prot  = prot_e'(cfg_prot);
    end

    bxlat_regs #(.N_ENT(N_ENT)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .idx   (cfg_idx),
        .wdata (wdata),
        .ents  (ents)
    );

    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        bxlat_cmp u_cmp (
            .clk   (clk),
            .rst   (rst),
            .ent   (ents[g]),
            .ea    (req_ea),
            .user  (req_user),
            .wr    (req_write),
            .match (match_v[g]),
            .viol  (viol_v[g]),
            .pa    (pa_v[g])
        );
    end

    // lowest index wins: scan downward so the last assignment is the smallest
    always_comb begin
        any_blk = 1'b0;
        sel     = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (match_v[i]) begin
                any_blk = 1'b1;
                sel     = i[IDX_W-1:0];
            end
        end
    end

    always_comb begin
        nxt = '0;
        if (req_valid) begin
            if (any_blk) begin
                nxt.from_blk = 1'b1;
                if (viol_v[sel]) begin
                    nxt.fault = 1'b1;
                end else begin
                    nxt.hit = 1'b1;
                    nxt.pa  = pa_v[sel];
                end
            end else if (tlb_hit) begin
                nxt.hit = 1'b1;
                nxt.pa  = tlb_pa;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            vld_q <= 1'b0;
        end else begin
            res_q <= nxt;
            vld_q <= req_valid;
        end
    end

    assign rsp_valid      = vld_q;
    assign rsp_hit        = res_q.hit;
    assign rsp_fault      = res_q.fault;
    assign rsp_from_block = res_q.from_blk;
    assign rsp_pa         = res_q.pa;

    assert_resp_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    assert_no_resp_without_req_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_hit && !rsp_fault));
    assert_fault_blocks_hit_R7: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (!rsp_hit && rsp_from_block && rsp_pa == '0));
    assert_block_beats_tlb_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && any_blk && tlb_hit) |=> rsp_from_block);
    assert_tlb_fallback_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !any_blk && tlb_hit) |=>
            (rsp_hit && !rsp_from_block && rsp_pa == $past(tlb_pa)));
    assert_one_winner_R5: assert property (@(posedge clk) disable iff (rst)
        any_blk |-> match_v[sel]);
endmodule

// File: tb/bxlat_unit_bench.sv
`timescale 1ns/1ps
module bxlat_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [14:0] cfg_ebase = '0;
    logic [10:0] cfg_mask = '0;
    logic [14:0] cfg_pbase = '0;
    logic        cfg_vs = 1'b0;
    logic        cfg_vu = 1'b0;
    logic [1:0]  cfg_prot = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_ea = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        tlb_hit = 1'b0;
    logic [31:0] tlb_pa = '0;
    logic        rsp_valid, rsp_hit, rsp_fault, rsp_from_block;
    logic [31:0] rsp_pa;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [14:0] m_eb [4];
    logic [10:0] m_mk [4];
    logic [14:0] m_pb [4];
    logic        m_vs [4];
    logic        m_vu [4];
    logic [1:0]  m_pr [4];

    always #10 clk = ~clk;

    bxlat_unit u_bxlat_unit (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_ebase(cfg_ebase),
        .cfg_mask(cfg_mask), .cfg_pbase(cfg_pbase), .cfg_vs(cfg_vs),
        .cfg_vu(cfg_vu), .cfg_prot(cfg_prot),
        .req_valid(req_valid), .req_ea(req_ea), .req_write(req_write),
        .req_user(req_user), .tlb_hit(tlb_hit), .tlb_pa(tlb_pa),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
        .rsp_from_block(rsp_from_block), .rsp_pa(rsp_pa)
    );

    // expected {hit, fault, from_block, pa}
    function automatic logic [34:0] model(input logic [31:0] ea, input logic wr,
                                          input logic usr, input logic th,
                                          input logic [31:0] tp);
        for (int i = 0; i < 4; i++) begin
            logic [14:0] me;
            logic [10:0] nx;
            logic ok_priv, ok_shape, ok_tag, allow;
            me       = {4'b0, m_mk[i]};
            nx       = m_mk[i] + 11'd1;
            ok_shape = (m_mk[i] & nx) == 11'd0;
            ok_priv  = usr ? m_vu[i] : m_vs[i];
            ok_tag   = ((ea[31:17] ^ m_eb[i]) & ~me) == 15'd0;
            if (ok_shape && ok_priv && ok_tag) begin
                allow = (m_pr[i] == 2'b00) ? 1'b0 : (m_pr[i] == 2'b01) ? !wr : 1'b1;
                if (!allow) return {3'b011, 32'd0};
                return {3'b101, (m_pb[i] & ~me) | (ea[31:17] & me), ea[16:0]};
            end
        end
        if (th) return {3'b100, tp};
        return 35'd0;
    endfunction

    task automatic check(input string tag, input logic [34:0] act, input logic [34:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual hit/fault/blk/pa=%b%b%b/%h expected %b%b%b/%h",
                     tag, act[34], act[33], act[32], act[31:0],
                     exp[34], exp[33], exp[32], exp[31:0]);
        end
    endtask

    task automatic put_win(input int i, input logic [14:0] eb, input logic [10:0] mk,
                           input logic [14:0] pb, input logic vs, input logic vu,
                           input logic [1:0] pr);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 2'(i); cfg_ebase = eb; cfg_mask = mk;
        cfg_pbase = pb; cfg_vs = vs; cfg_vu = vu; cfg_prot = pr;
        @(negedge clk);
        cfg_we = 1'b0;
        m_eb[i] = eb; m_mk[i] = mk; m_pb[i] = pb; m_vs[i] = vs; m_vu[i] = vu; m_pr[i] = pr;
    endtask

    task automatic look(input string tag, input logic [31:0] ea, input logic wr,
                        input logic usr, input logic th, input logic [31:0] tp);
        logic [34:0] exp;
        @(negedge clk);
        req_valid = 1'b1; req_ea = ea; req_write = wr; req_user = usr;
        tlb_hit = th; tlb_pa = tp;
        exp = model(ea, wr, usr, th, tp);
        @(negedge clk);
        req_valid = 1'b0; tlb_hit = 1'b0;
        check({tag, " R2"}, {1'b0, 1'b0, 1'b0, 31'd0, rsp_valid},
              {1'b0, 1'b0, 1'b0, 31'd0, 1'b1});
        check(tag, {rsp_hit, rsp_fault, rsp_from_block, rsp_pa}, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 4; i++) begin
            m_eb[i] = '0; m_mk[i] = '0; m_pb[i] = '0;
            m_vs[i] = 1'b0; m_vu[i] = 1'b0; m_pr[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: outputs cleared, windows invalid
        check("R1 reset outputs", {rsp_hit, rsp_fault, rsp_from_block, rsp_pa}, 35'd0);
        check("R1 reset valid", {34'd0, rsp_valid}, 35'd0);
        look("R1 empty array", 32'h0000_0000, 1'b0, 1'b0, 1'b0, 32'h0);

        // R3: 128K window and 256M window
        put_win(0, 15'h4000, 11'h000, 15'h0800, 1, 1, 2'b10);
        look("R3 small window", 32'h8001_2345, 1'b0, 1'b0, 1'b0, 32'h0);
        look("R3 small window miss", 32'h8003_2345, 1'b0, 1'b0, 1'b0, 32'h0);
        put_win(1, 15'h1000, 11'h7FF, 15'h7000, 1, 1, 2'b11);
        look("R3 large window", 32'h2ABC_DEF0, 1'b1, 1'b0, 1'b0, 32'h0);

        // R4: non-contiguous mask never hits
        put_win(2, 15'h0100, 11'h005, 15'h0200, 1, 1, 2'b10);
        look("R4 odd mask", 32'h0200_0000, 1'b0, 1'b0, 1'b0, 32'h0);
        look("R4 odd mask tlb", 32'h0202_0000, 1'b0, 1'b0, 1'b1, 32'hCAFE_0000);

        // R5: window 1 and 2 overlap; lower index supplies result
        put_win(2, 15'h1040, 11'h00F, 15'h3000, 1, 1, 2'b10);
        look("R5 lowest index", 32'h2080_1111, 1'b0, 1'b0, 1'b0, 32'h0);
        // R7/R5: lower window faulting does not fall through
        put_win(1, 15'h1000, 11'h7FF, 15'h7000, 1, 1, 2'b00);
        look("R7 none faults read R5", 32'h2080_1111, 1'b0, 1'b0, 1'b1, 32'h1);
        put_win(1, 15'h1000, 11'h7FF, 15'h7000, 1, 1, 2'b01);
        look("R7 ro read ok", 32'h2080_1111, 1'b0, 1'b0, 1'b0, 32'h0);
        look("R7 ro write faults", 32'h2080_1111, 1'b1, 1'b0, 1'b1, 32'h55);

        // R6: privilege valid bits
        put_win(3, 15'h7F00, 11'h001, 15'h0010, 1'b0, 1'b1, 2'b10);
        look("R6 user valid", 32'hFE03_0000, 1'b0, 1'b1, 1'b0, 32'h0);
        look("R6 super invalid", 32'hFE03_0000, 1'b0, 1'b0, 1'b0, 32'h0);

        // R8: block beats TLB; R9 fallback and double miss
        look("R8 block over tlb", 32'h8000_0004, 1'b0, 1'b0, 1'b1, 32'hDEAD_BEEF);
        look("R9 tlb only", 32'h6000_0000, 1'b0, 1'b0, 1'b1, 32'h1234_5678);
        look("R9 no hit", 32'h6000_0000, 1'b0, 1'b0, 1'b0, 32'h1234_5678);

        // R10: idle cycle after a hit
        look("R10 prep", 32'h8000_0004, 1'b0, 1'b0, 1'b0, 32'h0);
        @(negedge clk);
        check("R10 idle", {rsp_hit, rsp_fault, 32'd0, rsp_valid}, 35'd0);

        // R11: write and lookup in same cycle uses old content, next sees new
        begin
            logic [34:0] exp;
            @(negedge clk);
            cfg_we = 1'b1; cfg_idx = 2'd0; cfg_ebase = 15'h4000; cfg_mask = 11'h000;
            cfg_pbase = 15'h0800; cfg_vs = 1'b0; cfg_vu = 1'b0; cfg_prot = 2'b10;
            req_valid = 1'b1; req_ea = 32'h8000_0100; req_write = 1'b0; req_user = 1'b0;
            tlb_hit = 1'b0;
            exp = model(32'h8000_0100, 1'b0, 1'b0, 1'b0, 32'h0);
            @(negedge clk);
            cfg_we = 1'b0; req_valid = 1'b0;
            m_vs[0] = 1'b0; m_vu[0] = 1'b0;
            check("R11 same cycle old", {rsp_hit, rsp_fault, rsp_from_block, rsp_pa}, exp);
        end
        look("R11 next cycle new", 32'h8000_0100, 1'b0, 1'b0, 1'b0, 32'h0);

        // random phase
        for (int n = 0; n < 600; n++) begin
            if ($urandom % 4 == 0) begin
                logic [10:0] mk;
                if ($urandom % 6 == 0) mk = 11'($urandom);
                else mk = 11'((32'd1 << ($urandom % 12)) - 1);
                put_win(int'($urandom % 4), 15'($urandom), mk, 15'($urandom),
                        1'($urandom), 1'($urandom), 2'($urandom));
            end else begin
                int j;
                logic [14:0] hi;
                j = int'($urandom % 4);
                if ($urandom % 5 == 0) hi = 15'($urandom);
                else hi = m_eb[j] ^ (15'($urandom) & {4'b0, m_mk[j]});
                look("R3 R5 R7 R8 R9 random", {hi, 17'($urandom)}, 1'($urandom),
                     1'($urandom), 1'($urandom), $urandom);
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule